// File: doc/BRIEF.md
# Page Write Latch and Commit Sequencer

This block sits between a serial-memory slave protocol engine and the nonvolatile array. The engine opens a write instruction by handing over the full byte address, then forwards each received data byte. The block collects up to one page of bytes in a local store, marking every byte it holds with its own valid flag. The store is indexed by the low address bits, and a running pointer wraps inside the page. The block also decides whether each data byte is acknowledged, which depends on the write-protect input.

When the engine reports a stop condition, the block checks where it landed. A stop that comes right after an acknowledged data byte, before any bit of a further byte, starts the internal write cycle. Any other stop, or a start condition in the middle of an instruction, throws the collected bytes away. The write cycle holds `busy_o` for a fixed number of clock cycles. During that time it copies every valid byte to the array, one per clock, through a plain write port. When the cycle ends, it loads the shared address counter with the location that follows the last byte received. While busy, the block ignores every engine input.

A single-byte write follows the same path as a page write with one byte.

Top module: `page_commit_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o`, `ack_vld_o`, `ack_o` and `addr_upd_o` are 0 and `addr_cnt_o` is 0.
- R2: A data byte received with `wc_i` low during an open instruction produces `ack_vld_o`=1 with `ack_o`=1 (1 = ACK) one clock after `data_valid_i`.
- R3: A data byte received with `wc_i` high produces `ack_vld_o`=1 with `ack_o`=0 (NoAck). That byte is never written to the array, although the in-page pointer still advances past it.
- R4: A stop (`stop_i`) that follows an acknowledged data byte, with no `bit_i` in between, raises `busy_o` two clocks after the stop. `busy_o` then stays high for exactly `TW_CYCLES` clocks.
- R5: The following events end the instruction without a write cycle: a stop after a `bit_i` pulse, a stop after a NoAck byte, or a `start_i`. In each case `busy_o` stays low and no array write occurs.
- R6: During a write cycle, every offset whose byte was received with ACK is written exactly once, with the latest data. Offsets are written in rising order. The array address is {page bits A[ADDR_W-1:5], offset A[4:0]}, and no other address is written.
- R7: Bytes sent beyond offset 31 wrap to offset 0 of the same page and overwrite earlier bytes there.
- R8: On the clock where `busy_o` falls, `addr_upd_o` pulses for one clock. At the same time `addr_cnt_o` becomes {same page, offset after the last received byte, modulo 32}.
- R9: While `busy_o` is high, `data_valid_i`, `instr_start_i`, `start_i` and `stop_i` have no effect. No `ack_vld_o` pulse occurs and no second write cycle follows.
- R10: A one-byte instruction is committed and written like a page write of length 1.
- R11: Valid flags are cleared when a new instruction opens, so bytes from a discarded instruction never reach the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wc_i | input | 1 | Write protect, 1 = protected |
| instr_start_i | input | 1 | Pulse: write instruction opens, address valid |
| base_addr_i | input | ADDR_W | Start byte address of the instruction |
| data_valid_i | input | 1 | Pulse: one data byte received |
| data_i | input | DATA_W | Received data byte |
| bit_i | input | 1 | Pulse: a bit of a following byte was sampled |
| start_i | input | 1 | Pulse: start or repeated start seen on the bus |
| stop_i | input | 1 | Pulse: stop seen on the bus |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NoAck for the last data byte |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| addr_cnt_o | output | ADDR_W | Shared address counter value |
| addr_upd_o | output | 1 | Pulse: address counter was loaded |

## Verification
The bench drives every input on a falling edge and samples on the next falling edge, so each register stage counts as exactly one clock. The acknowledge decision is checked one clock after its data byte. `busy_o` is checked as still low one clock after the stop and high two clocks after it. The bench then counts the clocks while `busy_o` stays high and compares the count with `TW_CYCLES`. The counter update is checked on the first sample where `busy_o` is low again. A monitor records array writes at every falling edge, and the recorded set is compared with a page image that the bench builds from the byte stream it sent.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // per-byte request from the qualifier to the store
  typedef struct packed {
    logic step;   // a data byte arrived: advance the in-page pointer
    logic store;  // the byte was acknowledged: keep it
  } byte_req_t;

  // the timed cycle must be long enough to drain the whole store
  function automatic int unsigned tw_floor(input int unsigned tw,
                                           input int unsigned page);
    return (tw > page + 4) ? tw : page + 4;
  endfunction

endpackage

// File: rtl/pcs_latch.sv
module pcs_latch
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_i,
  input  logic [ADDR_W-1:0]          base_i,
  input  logic                       clear_i,
  input  byte_req_t                  req_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       rd_vld_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic [$clog2(PAGE_BYTES)-1:0] ptr_o
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic [DATA_W-1:0]     store_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [OFF_W-1:0]      ptr_q;
  logic [PAGE_W-1:0]     page_q;

  // storage without reset so it maps onto RAM; registered read port
  always_ff @(posedge clk) begin
    if (req_i.step && req_i.store) store_q[ptr_q] <= data_i;
    rd_data_o <= store_q[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      ptr_q    <= '0;
      page_q   <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= valid_q[rd_idx_i];
      if (load_i) begin
        valid_q <= '0;
        ptr_q   <= base_i[OFF_W-1:0];
        page_q  <= base_i[ADDR_W-1:OFF_W];
      end else if (clear_i) begin
        valid_q <= '0;
      end else if (req_i.step) begin
        ptr_q <= ptr_q + OFF_W'(1);
        if (req_i.store) valid_q[ptr_q] <= 1'b1;
      end
    end
  end

  assign page_o = page_q;
  assign ptr_o  = ptr_q;

endmodule

// File: rtl/pcs_qualify.sv
module pcs_qualify
  import pcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      busy_i,
  input  logic      wc_i,
  input  logic      instr_start_i,
  input  logic      data_valid_i,
  input  logic      bit_i,
  input  logic      start_i,
  input  logic      stop_i,
  output logic      load_o,
  output byte_req_t req_o,
  output logic      ack_vld_o,
  output logic      ack_o,
  output logic      commit_o,
  output logic      discard_o
);
  logic open_q;   // a write instruction is collecting bytes
  logic armed_q;  // last slot was an ACKed data byte, no bit since

  logic take;
  assign take = !busy_i && open_q && data_valid_i && !start_i && !stop_i;

  assign load_o      = !busy_i && instr_start_i && !start_i;
  assign req_o.step  = take;
  assign req_o.store = take && !wc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      armed_q   <= 1'b0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
      commit_o  <= 1'b0;
      discard_o <= 1'b0;
    end else begin
      ack_vld_o <= take;
      ack_o     <= take && !wc_i;
      commit_o  <= 1'b0;
      discard_o <= 1'b0;
      if (!busy_i) begin
        if (start_i) begin
          open_q    <= 1'b0;
          armed_q   <= 1'b0;
          discard_o <= open_q;
        end else if (instr_start_i) begin
          open_q  <= 1'b1;
          armed_q <= 1'b0;
        end else if (stop_i) begin
          open_q    <= 1'b0;
          armed_q   <= 1'b0;
          commit_o  <= open_q && armed_q;
          discard_o <= open_q && !armed_q;
        end else if (take) begin
          armed_q <= !wc_i;
        end else if (bit_i) begin
          armed_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pcs_commit.sv
module pcs_commit
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TW_CYCLES  = 250000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] end_i,
  output logic [$clog2(PAGE_BYTES)-1:0] rd_idx_o,
  input  logic [DATA_W-1:0]             rd_data_i,
  input  logic                          rd_vld_i,
  output logic                          busy_o,
  output logic                          mem_we_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  output logic [ADDR_W-1:0]             addr_cnt_o,
  output logic                          addr_upd_o
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam int unsigned TW_EFF = tw_floor(TW_CYCLES, PAGE_BYTES);
  localparam int unsigned CNT_W  = $clog2(TW_EFF + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  end_q;
  logic              scan;
  logic              scan_d1;
  logic [OFF_W-1:0]  idx_d1;

  assign scan     = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign rd_idx_o = cnt_q[OFF_W-1:0];

  // tW timer and address counter update
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      page_q     <= '0;
      end_q      <= '0;
      addr_cnt_o <= '0;
      addr_upd_o <= 1'b0;
    end else begin
      addr_upd_o <= 1'b0;
      if (!busy_o) begin
        if (commit_i) begin
          busy_o <= 1'b1;
          cnt_q  <= '0;
          page_q <= page_i;
          end_q  <= end_i;
        end
      end else if (cnt_q == CNT_W'(TW_EFF - 1)) begin
        busy_o     <= 1'b0;
        addr_cnt_o <= {page_q, end_q};
        addr_upd_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // scan of the store: index -> registered read -> registered write port
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_d1     <= 1'b0;
      idx_d1      <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      scan_d1     <= scan;
      idx_d1      <= cnt_q[OFF_W-1:0];
      mem_we_o    <= scan_d1 && rd_vld_i;
      mem_addr_o  <= {page_q, idx_d1};
      mem_wdata_o <= rd_data_i;
    end
  end

endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TW_CYCLES  = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wc_i,
  input  logic              instr_start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] addr_cnt_o,
  output logic              addr_upd_o
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic              load;
  byte_req_t         req;
  logic              commit;
  logic              discard;
  logic [OFF_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  ptr;

  pcs_qualify u_qual (
    .clk           (clk),
    .rst           (rst),
    .busy_i        (busy_o),
    .wc_i          (wc_i),
    .instr_start_i (instr_start_i),
    .data_valid_i  (data_valid_i),
    .bit_i         (bit_i),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .load_o        (load),
    .req_o         (req),
    .ack_vld_o     (ack_vld_o),
    .ack_o         (ack_o),
    .commit_o      (commit),
    .discard_o     (discard)
  );

  pcs_latch #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .base_i    (base_addr_i),
    .clear_i   (discard),
    .req_i     (req),
    .data_i    (data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .page_o    (page),
    .ptr_o     (ptr)
  );

  pcs_commit #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .TW_CYCLES  (TW_CYCLES)
  ) u_commit (
    .clk         (clk),
    .rst         (rst),
    .commit_i    (commit),
    .page_i      (page),
    .end_i       (ptr),
    .rd_idx_o    (rd_idx),
    .rd_data_i   (rd_data),
    .rd_vld_i    (rd_vld),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .addr_cnt_o  (addr_cnt_o),
    .addr_upd_o  (addr_upd_o)
  );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_BYTES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wc_i,
  input logic              ack_vld_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              addr_upd_o
);
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES);

  // R3
  ack_needs_wc_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_vld_o && ack_o) |-> !$past(wc_i));

  // R9
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy_o) |-> !ack_vld_o);

  // R6
  we_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);

  // R6
  page_held_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o) && $past(busy_o) && busy_o) |->
      (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W])));

  // R6
  offset_rising_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o) && $past(busy_o) && busy_o) |->
      (mem_addr_o[OFF_W-1:0] > $past(mem_addr_o[OFF_W-1:0])));

  // R8
  upd_on_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    addr_upd_o |-> $fell(busy_o));

  // R4
  busy_min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |=> busy_o);

endmodule

bind page_commit_seq pcs_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES)
) u_pcs_checker (
  .clk        (clk),
  .rst        (rst),
  .wc_i       (wc_i),
  .ack_vld_o  (ack_vld_o),
  .ack_o      (ack_o),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .addr_upd_o (addr_upd_o)
);

// File: tb/test_page_commit_seq.sv
module test_page_commit_seq;
  localparam int ADDR_W = 13;
  localparam int PAGE   = 32;
  localparam int DATA_W = 8;
  localparam int TW     = 64;
  localparam int NVEC   = 10;

  // {end_kind[1:0], nack_first, d0[7:0], len[7:0], base[12:0]}
  // end_kind: 0 = stop right after last byte, 1 = bit then stop, 2 = start
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 8'h5A, 8'd1,  13'h0040},  // R10 single byte
    {2'd0, 1'b0, 8'h11, 8'd4,  13'h1234},  // R6
    {2'd0, 1'b0, 8'h80, 8'd6,  13'h00FD},  // R7 wrap 29..2
    {2'd1, 1'b0, 8'h33, 8'd3,  13'h0101},  // R5 stop after bit
    {2'd2, 1'b0, 8'h44, 8'd5,  13'h0200},  // R5 restart
    {2'd0, 1'b0, 8'h21, 8'd2,  13'h0300},  // R11 after discards
    {2'd0, 1'b0, 8'h01, 8'd40, 13'h1FE0},  // R7 overwrite
    {2'd0, 1'b1, 8'h70, 8'd3,  13'h0405},  // R3 first byte NoAck
    {2'd0, 1'b1, 8'h90, 8'd1,  13'h0500},  // R3/R5 only byte NoAck
    {2'd0, 1'b0, 8'hC3, 8'd1,  13'h1FFF}   // R8 counter wrap
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wc_i = 1'b0;
  logic              instr_start_i = 1'b0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic              data_valid_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              bit_i = 1'b0;
  logic              start_i = 1'b0;
  logic              stop_i = 1'b0;
  logic              ack_vld_o, ack_o, busy_o, mem_we_o, addr_upd_o;
  logic [ADDR_W-1:0] mem_addr_o, addr_cnt_o;
  logic [DATA_W-1:0] mem_wdata_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // write monitor
  int          cap_cnt;
  int          cap_hit [PAGE];
  logic [7:0]  cap_dat [PAGE];
  logic [7:0]  cap_page;
  logic        cap_bad_page;

  logic        exp_vld [PAGE];
  logic [7:0]  exp_dat [PAGE];

  page_commit_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .DATA_W(DATA_W), .TW_CYCLES(TW)
  ) i_page_commit_seq (
    .clk(clk), .rst(rst), .wc_i(wc_i), .instr_start_i(instr_start_i),
    .base_addr_i(base_addr_i), .data_valid_i(data_valid_i), .data_i(data_i),
    .bit_i(bit_i), .start_i(start_i), .stop_i(stop_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .addr_cnt_o(addr_cnt_o), .addr_upd_o(addr_upd_o)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (mem_we_o) begin
      cap_cnt++;
      cap_hit[mem_addr_o[4:0]]++;
      cap_dat[mem_addr_o[4:0]] = mem_wdata_o;
      if (mem_addr_o[12:5] != cap_page) cap_bad_page = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [31:0] v, input bit poke);
    logic [12:0] base;
    int          len;
    logic [7:0]  d0;
    logic        nk;
    logic [1:0]  ek;
    logic [4:0]  off;
    logic        commit_exp;
    int          nexp;
    int          cnt;
    bit          busy_seen;
    base = v[12:0]; len = int'(v[20:13]); d0 = v[28:21]; nk = v[29]; ek = v[31:30];
    for (int k = 0; k < PAGE; k++) begin exp_vld[k] = 1'b0; exp_dat[k] = '0; end
    instr_start_i = 1'b1; base_addr_i = base; tick();
    instr_start_i = 1'b0;
    off = base[4:0];
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin bit_i = 1'b1; tick(); bit_i = 1'b0; end
      wc_i = (nk && i == 0);
      data_valid_i = 1'b1; data_i = d0 + 8'(i * 7); tick();
      data_valid_i = 1'b0;
      if (wc_i) chk(ack_vld_o && !ack_o, "R3 NoAck with wc high", int'({ack_vld_o, ack_o}), 2);
      else      chk(ack_vld_o && ack_o,  "R2 ACK with wc low",    int'({ack_vld_o, ack_o}), 3);
      if (!wc_i) begin exp_vld[off] = 1'b1; exp_dat[off] = data_i; end
      wc_i = 1'b0;
      off = off + 5'd1;
    end
    commit_exp = (ek == 2'd0) && (len > 0) && !(nk && len == 1);
    cap_cnt = 0; cap_bad_page = 1'b0; cap_page = base[12:5];
    for (int k = 0; k < PAGE; k++) begin cap_hit[k] = 0; cap_dat[k] = '0; end
    if (ek == 2'd1) begin bit_i = 1'b1; tick(); bit_i = 1'b0; end
    if (ek == 2'd2) start_i = 1'b1; else stop_i = 1'b1;
    tick();
    start_i = 1'b0; stop_i = 1'b0;
    chk(!busy_o, "R4 busy low one clock after stop", int'(busy_o), 0);
    tick();
    if (commit_exp) begin
      chk(busy_o, "R4 busy high two clocks after stop", int'(busy_o), 1);
      cnt = 0;
      while (busy_o) begin
        cnt++;
        if (poke && cnt == 5) begin data_valid_i = 1'b1; instr_start_i = 1'b1; base_addr_i = 13'h0777; end
        if (poke && cnt == 6) begin
          data_valid_i = 1'b0; instr_start_i = 1'b0;
          chk(!ack_vld_o, "R9 no ack while busy", int'(ack_vld_o), 0);
          stop_i = 1'b1;
        end
        if (poke && cnt == 7) stop_i = 1'b0;
        tick();
      end
      chk(cnt == TW, "R4 busy length", cnt, TW);
      chk(addr_upd_o, "R8 counter update pulse", int'(addr_upd_o), 1);
      chk(addr_cnt_o == {base[12:5], off}, "R8 counter value", int'(addr_cnt_o), int'({base[12:5], off}));
      nexp = 0;
      for (int k = 0; k < PAGE; k++) if (exp_vld[k]) nexp++;
      chk(cap_cnt == nexp, "R6 R11 write count", cap_cnt, nexp);
      chk(!cap_bad_page, "R6 page of writes", int'(cap_bad_page), 0);
      for (int k = 0; k < PAGE; k++) begin
        if (exp_vld[k]) begin
          chk(cap_hit[k] == 1 && cap_dat[k] == exp_dat[k], "R6 R7 written byte",
              int'(cap_dat[k]), int'(exp_dat[k]));
        end else if (cap_hit[k] != 0) begin
          chk(1'b0, "R3 R11 unexpected write", k, -1);
        end
      end
      if (poke) begin
        busy_seen = 1'b0;
        for (int k = 0; k < 8; k++) begin if (busy_o) busy_seen = 1'b1; tick(); end
        chk(!busy_seen, "R9 no second cycle", int'(busy_seen), 0);
      end
    end else begin
      busy_seen = 1'b0;
      for (int k = 0; k < TW + 6; k++) begin if (busy_o) busy_seen = 1'b1; tick(); end
      chk(!busy_seen, "R5 no write cycle", int'(busy_seen), 0);
      chk(cap_cnt == 0, "R5 no array write", cap_cnt, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk(!busy_o && !mem_we_o && !ack_vld_o && !ack_o && !addr_upd_o,
        "R1 reset outputs", int'({busy_o, mem_we_o, ack_vld_o, ack_o, addr_upd_o}), 0);
    chk(addr_cnt_o == '0, "R1 reset counter", int'(addr_cnt_o), 0);
    // table walk
    for (int n = 0; n < NVEC; n++) begin
      run_txn(VEC[n], 1'b0);
      repeat (2) tick();
    end
    // R9 directed: inputs poked during busy
    run_txn({2'd0, 1'b0, 8'hA0, 8'd3, 13'h0A1C}, 1'b1);
    // R11 directed: discard a full page, then a one-byte write
    run_txn({2'd2, 1'b0, 8'h10, 8'd32, 13'h0600}, 1'b0);
    run_txn({2'd0, 1'b0, 8'hE7, 8'd1,  13'h0610}, 1'b0);
    // R5 directed: stop with no data byte at all
    run_txn({2'd0, 1'b0, 8'h00, 8'd0,  13'h0700}, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule